// File: doc/BRIEF.md
# Unlock-Pattern Store/Recall Command Detector

This block watches the accesses a host makes to a memory and looks for one of two fixed unlock patterns. Each pattern is six reads at fixed addresses. The two patterns share their first five addresses, and the sixth address decides which command is raised: a store request or a recall request. Each access arrives as a one-cycle strobe that carries a write flag and a 13-bit address. Cycles without a strobe are ignored, and output-enable state plays no part in the match. The block only observes the access stream, so ordinary reads and writes finish normally whatever the matcher is doing.

A pattern that is complete and uninterrupted produces a registered, single-cycle request in the cycle after the sixth strobe. Any write, or any read that is not the next expected address, throws away the partial match. A `busy` input from the transfer controller keeps the matcher idle while a transfer is running.

Top module: `unlock_seq_det`

## Requirements
- R1: Synchronous reset (`rst` high) drives `store_req` and `recall_req` low and discards any partial match.
- R2: Reads at 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, in that order, followed by a read at 0x0F0F raise `store_req` for one cycle. The pulse appears in the cycle after the sixth strobe.
- R3: The same five reads followed by a read at 0x0F0E raise `recall_req` for one cycle, with the same timing as R2.
- R4: A write strobe at any step aborts the match, even when its address is the expected one. No command is raised on that strobe.
- R5: A read at an address other than the next expected one aborts the match. This includes a sixth read at any address other than 0x0F0E or 0x0F0F.
- R6: When a read at 0x0000 causes the abort, it is counted as step one of a new attempt.
- R7: Cycles with `acc_vld` low between strobes neither advance nor abort the match.
- R8: Each request lasts exactly one cycle, and `store_req` and `recall_req` are never high together.
- R9: While `busy` is high, strobes are not counted and no request is raised. A busy cycle that occurs partway through a pattern discards the partial match.
- R10: After a command has been raised, the matcher starts again from step one, so a second full pattern raises a second command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busy | input | 1 | Transfer in progress; holds the matcher idle |
| acc_vld | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 13 | Access address |
| store_req | output | 1 | One-cycle store command |
| recall_req | output | 1 | One-cycle recall command |

## Verification
The hardest case to reach is an abort caused by a read of 0x0000 partway through a pattern. That read must both discard the old progress and count as step one of a new attempt. The stimulus reaches this case by running three correct reads, then 0x0000, and then only the remaining five addresses. If the restart is not honoured, that shortened tail cannot raise a command. A second difficult case is a busy cycle that arrives between two correct strobes. The stimulus covers it by raising `busy` for a strobe-free cycle just before the final address.

// File: rtl/unlock_seq_det.sv
module unlock_seq_det #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              acc_vld,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              store_req,
  output logic              recall_req
);
  localparam logic [ADDR_W-1:0] P0       = ADDR_W'('h0000);
  localparam logic [ADDR_W-1:0] P1       = ADDR_W'('h1555);
  localparam logic [ADDR_W-1:0] P2       = ADDR_W'('h0AAA);
  localparam logic [ADDR_W-1:0] P3       = ADDR_W'('h1FFF);
  localparam logic [ADDR_W-1:0] P4       = ADDR_W'('h10F0);
  localparam logic [ADDR_W-1:0] STORE_A  = ADDR_W'('h0F0F);
  localparam logic [ADDR_W-1:0] RECALL_A = ADDR_W'('h0F0E);
  localparam logic [2:0]        LAST     = 3'd5;

  logic [2:0]        step;
  logic [ADDR_W-1:0] want;

  always_comb begin
    case (step)
      3'd0:    want = P0;
      3'd1:    want = P1;
      3'd2:    want = P2;
      3'd3:    want = P3;
      default: want = P4;
    endcase
  end

  wire rd      = acc_vld && !acc_wr && !busy;
  wire at_last = step == LAST;
  wire advance = rd && !at_last && acc_addr == want;
  wire fire_st = rd && at_last && acc_addr == STORE_A;
  wire fire_rc = rd && at_last && acc_addr == RECALL_A;

  always_ff @(posedge clk) begin
    if (rst) begin
      step       <= '0;
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      store_req  <= fire_st;
      recall_req <= fire_rc;
      if (busy)
        step <= '0;
      else if (acc_vld) begin
        if (advance)
          step <= step + 3'd1;
        else if (rd && acc_addr == P0)
          step <= 3'd1;
        else
          step <= '0;
      end
    end
  end
endmodule

module unlock_seq_det_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              acc_vld,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              store_req,
  input logic              recall_req
);
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({store_req, recall_req}));  // R8
  AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    store_req |=> !store_req);  // R8
  AST_RECALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    recall_req |=> !recall_req);  // R8
  AST_STORE_SRC: assert property (@(posedge clk) disable iff (rst)
    store_req |-> $past(acc_vld && !acc_wr && !busy && acc_addr == ADDR_W'('h0F0F)));  // R2
  AST_RECALL_SRC: assert property (@(posedge clk) disable iff (rst)
    recall_req |-> $past(acc_vld && !acc_wr && !busy && acc_addr == ADDR_W'('h0F0E)));  // R3
  AST_WRITE_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && acc_wr) |=> !(store_req || recall_req));  // R4
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
    busy |=> !(store_req || recall_req));  // R9
  AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    !acc_vld |=> !(store_req || recall_req));  // R7
endmodule

bind unlock_seq_det unlock_seq_det_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .acc_vld(acc_vld), .acc_wr(acc_wr),
  .acc_addr(acc_addr), .store_req(store_req), .recall_req(recall_req)
);

// File: tb/test_unlock_seq_det.sv
module test_unlock_seq_det;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busy = 1'b0;
  logic        acc_vld = 1'b0;
  logic        acc_wr = 1'b0;
  logic [12:0] acc_addr = '0;
  logic        store_req, recall_req;

  int n_chk = 0;
  int n_fail = 0;
  int st_cnt = 0;
  int rc_cnt = 0;
  int both_cnt = 0;

  localparam logic [12:0] STORE_A  = 13'h0F0F;
  localparam logic [12:0] RECALL_A = 13'h0F0E;

  always #2 clk = ~clk;

  unlock_seq_det i_unlock_seq_det (
    .clk(clk), .rst(rst), .busy(busy), .acc_vld(acc_vld), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .store_req(store_req), .recall_req(recall_req)
  );

  function automatic logic [12:0] pat(input int i);
    case (i)
      0: pat = 13'h0000;
      1: pat = 13'h1555;
      2: pat = 13'h0AAA;
      3: pat = 13'h1FFF;
      default: pat = 13'h10F0;
    endcase
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic sample();
    if (store_req) st_cnt++;
    if (recall_req) rc_cnt++;
    if (store_req && recall_req) both_cnt++;
  endtask

  task automatic clr();
    st_cnt = 0; rc_cnt = 0; both_cnt = 0;
  endtask

  task automatic acc(input logic wr, input logic [12:0] a);
    @(negedge clk);
    acc_vld = 1'b1; acc_wr = wr; acc_addr = a;
    @(negedge clk);
    acc_vld = 1'b0; acc_wr = 1'b0;
    sample();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample();
    end
  endtask

  task automatic prefix(input int from, input int upto);
    for (int i = from; i < upto; i++) acc(1'b0, pat(i));
  endtask

  task automatic t_reset();
    clr();
    check("R1 reset store_req", store_req, 0);
    check("R1 reset recall_req", recall_req, 0);
    prefix(0, 5);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    acc(1'b0, STORE_A);
    idle(2);
    check("R1 reset discards progress", st_cnt + rc_cnt, 0);
  endtask

  task automatic t_store();
    clr();
    prefix(0, 5);
    check("R2 no early store", st_cnt, 0);
    acc(1'b0, STORE_A);
    check("R2 store pulse after sixth read", st_cnt, 1);
    idle(1);
    check("R8 store lasts one cycle", st_cnt, 1);
    check("R3 no recall on store pattern", rc_cnt, 0);
  endtask

  task automatic t_recall();
    clr();
    prefix(0, 5);
    acc(1'b0, RECALL_A);
    check("R3 recall pulse after sixth read", rc_cnt, 1);
    idle(1);
    check("R8 recall lasts one cycle", rc_cnt, 1);
    check("R2 no store on recall pattern", st_cnt, 0);
  endtask

  task automatic t_write_abort();
    clr();
    prefix(0, 3);
    acc(1'b1, pat(3));
    prefix(4, 5);
    acc(1'b0, STORE_A);
    idle(1);
    check("R4 write at expected address aborts", st_cnt, 0);
    prefix(0, 5);
    acc(1'b1, STORE_A);
    idle(1);
    check("R4 write as sixth access gives no store", st_cnt, 0);
    acc(1'b0, STORE_A);
    idle(1);
    check("R4 progress lost after sixth write", st_cnt, 0);
  endtask

  task automatic t_bad_read();
    clr();
    prefix(0, 2);
    acc(1'b0, 13'h1234);
    prefix(2, 5);
    acc(1'b0, RECALL_A);
    idle(1);
    check("R5 stray read aborts", rc_cnt, 0);
    prefix(0, 5);
    acc(1'b0, 13'h0F0D);
    prefix(5, 5);
    acc(1'b0, STORE_A);
    idle(1);
    check("R5 wrong sixth address gives no command", st_cnt + rc_cnt, 0);
  endtask

  task automatic t_restart_zero();
    clr();
    prefix(0, 3);
    acc(1'b0, 13'h0000);
    prefix(1, 5);
    acc(1'b0, STORE_A);
    idle(1);
    check("R6 aborting 0x0000 is step one", st_cnt, 1);
    clr();
    acc(1'b0, 13'h0000);
    prefix(0, 5);
    acc(1'b0, RECALL_A);
    idle(1);
    check("R6 repeated 0x0000 restarts", rc_cnt, 1);
  endtask

  task automatic t_gaps();
    clr();
    for (int i = 0; i < 5; i++) begin
      acc(1'b0, pat(i));
      idle(i + 1);
    end
    acc(1'b0, STORE_A);
    idle(1);
    check("R7 gaps keep progress", st_cnt, 1);
  endtask

  task automatic t_busy();
    clr();
    @(negedge clk); busy = 1'b1;
    for (int i = 0; i < 5; i++) acc(1'b0, pat(i));
    acc(1'b0, STORE_A);
    idle(1);
    check("R9 strobes ignored while busy", st_cnt, 0);
    busy = 1'b0;
    prefix(5, 5);
    acc(1'b0, STORE_A);
    idle(1);
    check("R9 busy strobes not counted", st_cnt, 0);
    prefix(0, 5);
    @(negedge clk); busy = 1'b1;
    @(negedge clk); busy = 1'b0;
    sample();
    acc(1'b0, RECALL_A);
    idle(1);
    check("R9 busy cycle discards progress", rc_cnt, 0);
  endtask

  task automatic t_back_to_back();
    clr();
    prefix(0, 5);
    acc(1'b0, STORE_A);
    prefix(0, 5);
    acc(1'b0, RECALL_A);
    idle(1);
    check("R10 second pattern store count", st_cnt, 1);
    check("R10 second pattern recall count", rc_cnt, 1);
    check("R8 never both high", both_cnt, 0);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_store();
    t_recall();
    t_write_abort();
    t_bad_read();
    t_restart_zero();
    t_gaps();
    t_busy();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule